// File: doc/BRIEF.md
# Integer ALU with set-less-than

This block is the combinational arithmetic and logic unit of a 32-bit RISC datapath. Each evaluation takes two 32-bit operands, a 5-bit shift distance and a 4-bit operation code. It returns a 32-bit result, a zero flag and a signed-overflow flag. The operations are:

- add and subtract;
- bitwise AND, OR and NOR;
- logical shifts left and right by the shift-distance field;
- signed and unsigned set-less-than.

Bitwise inversion has no operation code of its own. It is obtained as NOR against a zero operand.

The surrounding decode logic turns instruction fields into the operation code. The result is valid in the same cycle the inputs settle, so it can feed a pipeline register directly. Shifts act on operand B. Their distance always comes from the shift-distance input, never from an operand. The two set-less-than variants can give different answers for the same bit patterns: one compares two's-complement values and the other compares raw unsigned values.

Top module: `alu_core`

## Requirements
- R1: Operation code 0 (add) returns (A + B) modulo 2^32.
- R2: Operation code 1 (subtract) returns (A - B) modulo 2^32.
- R3: The overflow flag is set on add when A and B have equal sign bits and the result sign differs from them. It is set on subtract when the A and B sign bits differ and the result sign differs from A. It is 0 for every other operation code.
- R4: Operation code 2 returns A AND B, and operation code 3 returns A OR B.
- R5: Operation code 4 returns NOT (A OR B). With B = 0 it returns the bitwise inverse of A.
- R6: Operation code 5 returns B shifted left by the shift distance, with zeros filling the vacated low bits. Operand A is ignored.
- R7: Operation code 6 returns B shifted right by the shift distance, with zeros filling the vacated high bits. Operand A is ignored.
- R8: A shift distance of 0 returns B unchanged, and a distance of 31 moves a single bit between the two end positions.
- R9: Operation code 7 returns 1 when A < B as two's-complement values and 0 otherwise. The comparison stays correct when A - B overflows.
- R10: Operation code 8 returns 1 when A < B as unsigned values and 0 otherwise. With A = 1 and B = 0xFFFFFFFF, code 7 returns 0 and code 8 returns 1.
- R11: For operation codes 0 to 8, the zero flag is 1 exactly when all 32 result bits are 0.
- R12: Operation codes 9 to 15 return a zero result with both the zero flag and the overflow flag cleared.
- R13: The shift distance has no effect on the result or the flags of any non-shift operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B; also the shifted value |
| shamt_i | input | 5 | Shift distance |
| op_i | input | 4 | Operation code (0..8 defined) |
| result_o | output | 32 | Result |
| zero_o | output | 1 | Result is all zeros (defined codes only) |
| ovf_o | output | 1 | Signed overflow on add or subtract |

## Verification
Every output is purely combinational, so each result and flag is due in the same cycle as the stimulus, with no register in the path. The bench applies a new stimulus on each falling clock edge and samples a quarter period later. Sampling there lets the values settle and keeps every comparison clear of the rising edge. The flags are always checked in the same sample as the result they describe.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SHAMT_W = $clog2(DATA_W);
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SLT  = 4'd7,
    OP_SLTU = 4'd8
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic [W-1:0] b_eff;
  logic         carry;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    {carry, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    ovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
    // valid when sub_i is set
    lt_s_o = sum_o[W-1] ^ ovf_o;
    lt_u_o = ~carry;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] nor_o
);
  always_comb begin
    and_o = a_i & b_i;
    or_o  = a_i | b_i;
    nor_o = ~or_o;
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [SW-1:0] shamt_i,
  input  logic          right_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0] stage [SW+1];

  assign stage[0] = val_i;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int unsigned DIST = 1 << s;
    always_comb begin
      if (!shamt_i[s])
        stage[s+1] = stage[s];
      else if (right_i)
        stage[s+1] = {{DIST{1'b0}}, stage[s][W-1:DIST]};
      else
        stage[s+1] = {stage[s][W-1-DIST:0], {DIST{1'b0}}};
    end
  end

  assign res_o = stage[SW];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
(
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [OP_W-1:0]    op_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               zero_o,
  output logic               ovf_o
);
  alu_op_e      op;
  logic         sub_en;
  logic [DATA_W-1:0] sum, and_r, or_r, nor_r, shf_r;
  logic         add_ovf, lt_s, lt_u;

  assign op     = alu_op_e'(op_i);
  assign sub_en = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_en),
    .sum_o(sum), .ovf_o(add_ovf), .lt_s_o(lt_s), .lt_u_o(lt_u)
  );

  alu_logic #(.W(DATA_W)) u_logic (
    .a_i(a_i), .b_i(b_i), .and_o(and_r), .or_o(or_r), .nor_o(nor_r)
  );

  alu_shift #(.W(DATA_W), .SW(SHAMT_W)) u_shift (
    .val_i(b_i), .shamt_i(shamt_i), .right_i(op == OP_SRL), .res_o(shf_r)
  );

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    zero_o   = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        result_o = sum;
        ovf_o    = add_ovf;
      end
      OP_AND:  result_o = and_r;
      OP_OR:   result_o = or_r;
      OP_NOR:  result_o = nor_r;
      OP_SLL, OP_SRL: result_o = shf_r;
      OP_SLT:  result_o = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU: result_o = {{(DATA_W-1){1'b0}}, lt_u};
      default: result_o = '0;
    endcase
    if (op_i <= OP_W'(OP_SLTU)) zero_o = (result_o == '0);
  end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
(
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] result_o,
  input logic              zero_o,
  input logic              ovf_o
);
  always_comb begin
    assert_no_overflow_R3: assert (!(ovf_o && op_i != 4'd0 && op_i != 4'd1))
      else $error("overflow flag on non-arith op");
    assert_add_ovf_R3: assert (!(op_i == 4'd0 && a_i[DATA_W-1] != b_i[DATA_W-1] && ovf_o))
      else $error("add overflow with mixed signs");
    assert_zero_flag_R11: assert (!(zero_o && result_o != '0))
      else $error("zero flag with nonzero result");
    assert_slt_width_R9: assert (!((op_i == 4'd7 || op_i == 4'd8) && result_o[DATA_W-1:1] != '0))
      else $error("set-less-than wider than one bit");
    assert_unused_op_R12: assert (!(op_i > 4'd8 && (result_o != '0 || zero_o || ovf_o)))
      else $error("unused op produced output");
  end
endmodule

bind alu_core alu_core_chk u_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i),
  .result_o(result_o), .zero_o(zero_o), .ovf_o(ovf_o)
);

// File: tb/alu_core_test.sv
module alu_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic [4:0]  sh;
  logic [3:0]  op;
  logic [31:0] res;
  logic        zf, vf;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_core uut (
    .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op),
    .result_o(res), .zero_o(zf), .ovf_o(vf)
  );

  task automatic run(input string tag, input logic [3:0] o, input logic [31:0] x,
                     input logic [31:0] y, input logic [4:0] s,
                     input logic [31:0] er, input logic ez, input logic ev);
    @(negedge clk);
    op = o; a = x; b = y; sh = s;
    #(CLK_PERIOD/4);
    n_chk++;
    if (res !== er || zf !== ez || vf !== ev) begin
      n_bad++;
      $display("FAIL %s: res=%h z=%b v=%b expected res=%h z=%b v=%b",
               tag, res, zf, vf, er, ez, ev);
    end
  endtask

  task automatic t_reset;
    run("R1 reset idle", 4'd0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b1, 1'b0);
  endtask

  task automatic t_add;
    run("R1 add", 4'd0, 32'd5, 32'd7, 5'd0, 32'd12, 1'b0, 1'b0);
    run("R3 add ovf", 4'd0, 32'h7FFFFFFF, 32'd1, 5'd0, 32'h80000000, 1'b0, 1'b1);
    run("R3 add neg ovf", 4'd0, 32'h80000000, 32'h80000000, 5'd0, 32'h0, 1'b1, 1'b1);
    run("R11 add wrap", 4'd0, 32'hFFFFFFFF, 32'd1, 5'd0, 32'h0, 1'b1, 1'b0);
  endtask

  task automatic t_sub;
    run("R2 sub", 4'd1, 32'd10, 32'd3, 5'd0, 32'd7, 1'b0, 1'b0);
    run("R3 sub ovf", 4'd1, 32'h80000000, 32'd1, 5'd0, 32'h7FFFFFFF, 1'b0, 1'b1);
    run("R11 sub equal", 4'd1, 32'd5, 32'd5, 5'd0, 32'h0, 1'b1, 1'b0);
    run("R2 sub borrow", 4'd1, 32'd0, 32'd1, 5'd0, 32'hFFFFFFFF, 1'b0, 1'b0);
  endtask

  task automatic t_logic;
    run("R4 and", 4'd2, 32'hF0F0_FF00, 32'h3C3C_0FF0, 5'd0, 32'h3030_0F00, 1'b0, 1'b0);
    run("R4 or", 4'd3, 32'hF0F0_FF00, 32'h3C3C_0FF0, 5'd0, 32'hFCFC_FFF0, 1'b0, 1'b0);
    run("R11 and zero", 4'd2, 32'hAAAA_AAAA, 32'h5555_5555, 5'd0, 32'h0, 1'b1, 1'b0);
    run("R5 nor", 4'd4, 32'hF0F0_0000, 32'h0000_000F, 5'd0, 32'h0F0F_FFF0, 1'b0, 1'b0);
    run("R5 nor as not", 4'd4, 32'h1234_5678, 32'h0, 5'd0, ~32'h1234_5678, 1'b0, 1'b0);
  endtask

  task automatic t_shift;
    run("R6 sll", 4'd5, 32'hDEAD_BEEF, 32'h8000_0001, 5'd4, 32'h0000_0010, 1'b0, 1'b0);
    run("R8 sll 31", 4'd5, 32'h0, 32'h1, 5'd31, 32'h8000_0000, 1'b0, 1'b0);
    run("R8 sll 0", 4'd5, 32'hFFFF_FFFF, 32'h1357_9BDF, 5'd0, 32'h1357_9BDF, 1'b0, 1'b0);
    run("R7 srl", 4'd6, 32'hDEAD_BEEF, 32'hF000_0001, 5'd4, 32'h0F00_0000, 1'b0, 1'b0);
    run("R8 srl 31", 4'd6, 32'h0, 32'h8000_0000, 5'd31, 32'h1, 1'b0, 1'b0);
    run("R11 srl out", 4'd6, 32'h0, 32'h0000_0001, 5'd1, 32'h0, 1'b1, 1'b0);
  endtask

  task automatic t_slt;
    run("R10 slt 1 vs -1", 4'd7, 32'd1, 32'hFFFF_FFFF, 5'd0, 32'h0, 1'b1, 1'b0);
    run("R10 sltu 1 vs max", 4'd8, 32'd1, 32'hFFFF_FFFF, 5'd0, 32'h1, 1'b0, 1'b0);
    run("R9 slt neg", 4'd7, 32'hFFFF_FFFB, 32'd3, 5'd0, 32'h1, 1'b0, 1'b0);
    run("R9 slt ovf case", 4'd7, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 32'h1, 1'b0, 1'b0);
    run("R9 slt ovf rev", 4'd7, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, 32'h0, 1'b1, 1'b0);
    run("R10 sltu equal", 4'd8, 32'h8000_0000, 32'h8000_0000, 5'd0, 32'h0, 1'b1, 1'b0);
    run("R10 sltu hi vs lo", 4'd8, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 32'h0, 1'b1, 1'b0);
  endtask

  task automatic t_unused;
    run("R12 op9", 4'd9, 32'h7FFF_FFFF, 32'd1, 5'd3, 32'h0, 1'b0, 1'b0);
    run("R12 op15", 4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_shamt_ignored;
    run("R13 add shamt", 4'd0, 32'h7FFF_FFFF, 32'd1, 5'd17, 32'h8000_0000, 1'b0, 1'b1);
    run("R13 or shamt", 4'd3, 32'h0000_00F0, 32'h0000_000F, 5'd31, 32'h0000_00FF, 1'b0, 1'b0);
    run("R13 sltu shamt", 4'd8, 32'd2, 32'd3, 5'd9, 32'h1, 1'b0, 1'b0);
  endtask

  initial begin
    a = '0; b = '0; sh = '0; op = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_slt();
    t_unused();
    t_shamt_ignored();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule